// File: doc/BRIEF.md
# Parallel transmit bus driver

This block takes bytes from an upstream valid/ready byte stream and drives them onto a parallel output bus of 1, 2, 4 or 8 data bits, one beat per clock. A start pulse begins a frame. The frame ends in one of two ways, chosen at start: a programmed length in bits, or the last-byte marker on the input stream. Between frames the bus carries a programmable 16-bit idle value. An optional valid output marks the beats that carry frame data.

The frame configuration (bus width, length, end-of-frame source, valid enable and bit reversal) is captured when a start is accepted and stays fixed until the frame ends. The idle value, interrupt enables and interrupt clears act live. Two raw interrupt flags are kept: frame done, and a read attempted from an empty stream in the middle of a frame. A counter reports how many bits have been taken from the stream since the last start.

Top module: `pbus_tx`

## Requirements
- R1: Width code `wsel` 0, 1, 2 and 3 selects 1, 2, 4 and 8 bits per beat. Each byte is sent least-significant bits first on `bus_o[w-1:0]`, so it takes 8, 4, 2 or 1 beats. The other bus bits are 0 during a frame. Before any start the captured width is code 3.
- R2: `ready_o` is 1 when no frame is active. A `start` seen at a clock edge while `ready_o` is 1 starts a frame, and `ready_o` reads 0 from the next cycle until the cycle in which the final beat appears. A `start` during a frame is ignored.
- R3: With `eof_sel`=0 (length mode), the frame ends with the beat at which the number of bits sent reaches `len_bits`. A length of 0 sends one beat. Bits of the final byte that were not sent are dropped. `s_last` is ignored.
- R4: With `eof_sel`=1 (marker mode), the frame ends with the final beat of the byte accepted with `s_last`=1. `len_bits` is ignored.
- R5: When no frame is active, `bus_o` shows the `idle_val` sampled at the previous clock edge, and `valid_o` is 0. Reset clears `bus_o` to 0.
- R6: `valid_o` is 1 exactly on cycles that show a new data beat, and only if `valid_en` was 1 at start.
- R7: With `bit_rev`=1 at start, each byte has its bit order reversed (bit 7 becomes bit 0) before it is split into beats.
- R8: If a frame needs a new byte and `s_valid` is 0, the bus holds its last value, `valid_o` is 0 in the next cycle and raw interrupt bit 1 (underrun) is set.
- R9: Raw interrupt bit 0 (frame done) is set in the same cycle that the final beat appears. `int_clr` bits clear the matching raw bits at the next edge, and a set at that same edge takes priority. `int_st_o` = `int_raw_o` & `int_en`.
- R10: `bits_read_o` is cleared by an accepted start and grows by 8 for each byte accepted from the stream.
- R11: `s_ready_o` is 1 only during a frame when a new byte is needed. When data is available the frame sends one beat on every clock, with no gap between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start a frame when ready |
| wsel | input | 2 | Bus width code |
| len_bits | input | 19 | Frame length in bits (length mode) |
| eof_sel | input | 1 | 0: length ends frame, 1: stream marker ends frame |
| valid_en | input | 1 | Enable the valid output |
| bit_rev | input | 1 | Reverse bit order of each byte |
| idle_val | input | 16 | Bus value between frames |
| int_en | input | 2 | Interrupt enables (bit 0 done, bit 1 underrun) |
| int_clr | input | 2 | Write-one clear of raw interrupt bits |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Stream byte is the last of the frame |
| s_ready_o | output | 1 | Block takes the stream byte |
| bus_o | output | 16 | Parallel output bus |
| valid_o | output | 1 | Bus carries a data beat |
| ready_o | output | 1 | No frame active; start accepted |
| int_raw_o | output | 2 | Raw interrupt flags |
| int_st_o | output | 2 | Masked interrupt flags |
| bits_read_o | output | 19 | Bits taken from the stream since start |

## Verification
A start at edge E0 makes `ready_o` low right after E0 and `s_ready_o` high in the same cycle. The byte taken at edge E1 shows its first beat on `bus_o` right after E1. Frame done, the return of `ready_o` and the final beat all appear together, and the idle value returns one edge later. An underrun shows in the raw flag and the held bus right after the edge that found the stream empty. The bench's reference model takes its inputs at every rising edge, and all outputs, including `s_ready_o`, are compared 2 ns after that edge. Results are therefore checked in exactly the cycle the timing above gives, never a cycle early or late.

// File: rtl/pbus_tx.sv
module pbus_tx #(
  parameter int BUS_W = 16,
  parameter int LEN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       wsel,
  input  logic [LEN_W-1:0] len_bits,
  input  logic             eof_sel,
  input  logic             valid_en,
  input  logic             bit_rev,
  input  logic [BUS_W-1:0] idle_val,
  input  logic [1:0]       int_en,
  input  logic [1:0]       int_clr,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready_o,
  output logic [BUS_W-1:0] bus_o,
  output logic             valid_o,
  output logic             ready_o,
  output logic [1:0]       int_raw_o,
  output logic [1:0]       int_st_o,
  output logic [LEN_W-1:0] bits_read_o
);

  function automatic logic [7:0] flip8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) flip8[i] = b[7-i];
  endfunction

  logic             busy;
  logic [1:0]       wsel_q;
  logic [LEN_W-1:0] len_q, sent_q;
  logic             eof_q, ven_q, rev_q;
  logic [7:0]       byte_q;
  logic             last_q;
  logic [2:0]       idx_q;

  logic [3:0]       wbits;
  logic [2:0]       last_idx;
  logic             need, take, beat_go, under;
  logic [7:0]       cur_byte, shifted, mask;
  logic             cur_last;
  logic [LEN_W:0]   nsent;
  logic             frame_end;

  assign wbits     = 4'd1 << wsel_q;
  assign last_idx  = 3'd7 >> wsel_q;
  assign need      = busy && (idx_q == 3'd0);
  assign take      = need && s_valid;
  assign under     = need && !s_valid;
  assign beat_go   = take || (busy && idx_q != 3'd0);
  assign cur_byte  = take ? (rev_q ? flip8(s_data) : s_data) : byte_q;
  assign cur_last  = take ? s_last : last_q;
  assign shifted   = cur_byte >> (idx_q * wbits);
  assign mask      = 8'((9'd1 << wbits) - 9'd1);
  assign nsent     = {1'b0, sent_q} + {{(LEN_W-3){1'b0}}, wbits};
  assign frame_end = beat_go && (eof_q ? (cur_last && idx_q == last_idx)
                                       : (nsent >= {1'b0, len_q}));

  assign s_ready_o = need;
  assign ready_o   = !busy;
  assign int_st_o  = int_raw_o & int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      wsel_q      <= 2'd3;
      len_q       <= '0;
      sent_q      <= '0;
      eof_q       <= 1'b0;
      ven_q       <= 1'b0;
      rev_q       <= 1'b0;
      byte_q      <= '0;
      last_q      <= 1'b0;
      idx_q       <= '0;
      bus_o       <= '0;
      valid_o     <= 1'b0;
      int_raw_o   <= '0;
      bits_read_o <= '0;
    end else begin
      int_raw_o <= (int_raw_o & ~int_clr) | {under, frame_end};
      if (!busy) begin
        bus_o   <= idle_val;
        valid_o <= 1'b0;
        if (start) begin
          busy        <= 1'b1;
          wsel_q      <= wsel;
          len_q       <= len_bits;
          eof_q       <= eof_sel;
          ven_q       <= valid_en;
          rev_q       <= bit_rev;
          sent_q      <= '0;
          idx_q       <= '0;
          bits_read_o <= '0;
        end
      end else begin
        valid_o <= beat_go && ven_q;
        if (beat_go) begin
          bus_o  <= {{(BUS_W-8){1'b0}}, shifted & mask};
          sent_q <= nsent[LEN_W-1:0];
          idx_q  <= (idx_q == last_idx) ? 3'd0 : idx_q + 3'd1;
        end
        if (take) begin
          byte_q      <= cur_byte;
          last_q      <= s_last;
          bits_read_o <= bits_read_o + LEN_W'(8);
        end
        if (frame_end) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pbus_tx_chk.sv
module pbus_tx_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] idle_val,
  input logic             s_valid,
  input logic             s_ready_o,
  input logic [BUS_W-1:0] bus_o,
  input logic             valid_o,
  input logic             ready_o,
  input logic [1:0]       int_raw_o
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  a_r5_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ready_o)) |-> (bus_o == $past(idle_val) && !valid_o));

  a_r8_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready_o && !s_valid) |=> ($stable(bus_o) && !valid_o && int_raw_o[1]));

  a_r11_no_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !s_ready_o);

  a_r9_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> int_raw_o[0]);

  a_r6_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (seen && !$past(ready_o)));

endmodule

bind pbus_tx pbus_tx_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_val(idle_val), .s_valid(s_valid),
  .s_ready_o(s_ready_o), .bus_o(bus_o), .valid_o(valid_o),
  .ready_o(ready_o), .int_raw_o(int_raw_o)
);

// File: tb/pbus_tx_tb_top.sv
`timescale 1ns/1ps
module pbus_tx_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] wsel = 2'd3, int_en = 2'd0, int_clr = 2'd0;
  logic [18:0] len_bits = '0;
  logic eof_sel = 0, valid_en = 0, bit_rev = 0;
  logic [15:0] idle_val = '0;
  logic [7:0] s_data = '0;
  logic s_valid = 0, s_last = 0;
  logic s_ready_o, valid_o, ready_o;
  logic [15:0] bus_o;
  logic [1:0] int_raw_o, int_st_o;
  logic [18:0] bits_read_o;

  always #5 clk = ~clk;

  pbus_tx dut_i (.*);

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R5";
  bit stall_mode = 0;
  logic [8:0] src[$];

  // reference model state
  bit m_busy = 0, m_valid = 0, m_lastbyte = 0;
  bit m_eof = 0, m_ven = 0, m_rev = 0;
  int m_w = 8, m_len = 0, m_sent = 0, m_bits = 0;
  logic [15:0] m_bus = '0;
  logic [1:0] m_raw = '0;
  bit bitq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    s_valid <= (src.size() > 0) && !(stall_mode && (cyc % 3 == 1));
    if (src.size() > 0) {s_last, s_data} <= src[0];
  end

  always @(posedge clk) begin
    bit set_done, set_und, go;
    logic [7:0] b;
    logic [15:0] beat;
    set_done = 0; set_und = 0;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_bus = '0; m_raw = '0; m_bits = 0; bitq.delete();
    end else begin
      if (!m_busy) begin
        m_bus = idle_val; m_valid = 0;
        if (start) begin
          m_busy = 1; m_w = 1 << wsel; m_len = int'(len_bits); m_eof = eof_sel;
          m_ven = valid_en; m_rev = bit_rev; m_sent = 0; m_bits = 0; bitq.delete();
        end
      end else begin
        m_valid = 0; go = 1;
        if (bitq.size() == 0) begin
          if (s_valid) begin
            b = m_rev ? {<<{s_data}} : s_data;
            for (int i = 0; i < 8; i++) bitq.push_back(b[i]);
            m_lastbyte = s_last; m_bits += 8;
            void'(src.pop_front());
          end else begin
            set_und = 1; go = 0;
          end
        end
        if (go) begin
          beat = '0;
          for (int i = 0; i < m_w; i++) beat[i] = bitq.pop_front();
          m_bus = beat; m_valid = m_ven; m_sent += m_w;
          if (m_eof ? (m_lastbyte && bitq.size() == 0) : (m_sent >= m_len)) begin
            m_busy = 0; set_done = 1; bitq.delete();
          end
        end
      end
      m_raw = (m_raw & ~int_clr) | {set_und, set_done};
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(bus_o === m_bus, tag, "bus_o", bus_o, m_bus);
      chk(valid_o === m_valid, "R6", "valid_o", valid_o, m_valid);
      chk(ready_o === !m_busy, "R2", "ready_o", ready_o, !m_busy);
      chk(s_ready_o === (m_busy && bitq.size() == 0), "R11", "s_ready_o",
          s_ready_o, (m_busy && bitq.size() == 0));
      chk(int_raw_o === m_raw, tag == "R8 R3" ? "R8" : "R9", "int_raw_o", int_raw_o, m_raw);
      chk(int_st_o === (m_raw & int_en), "R9", "int_st_o", int_st_o, m_raw & int_en);
      chk(bits_read_o === 19'(m_bits), "R10", "bits_read_o", bits_read_o, m_bits);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [1:0] w, input bit eofs, input bit ven, input bit rv,
                     input int ln, input int nb, input logic [7:0] seed, input bit mid_start);
    @(negedge clk);
    wsel = w; eof_sel = eofs; valid_en = ven; bit_rev = rv; len_bits = 19'(ln);
    for (int i = 0; i < nb; i++) src.push_back({(i == nb - 1), 8'(seed + i * 37)});
    start = 1; @(negedge clk); start = 0;
    if (mid_start) begin
      repeat (4) @(negedge clk);
      wsel = 2'd3; start = 1; @(negedge clk); start = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    src.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready_o && bus_o == 0 && !valid_o && int_raw_o == 0 && bits_read_o == 0,
        "R5", "reset state", {ready_o, bus_o}, {1'b1, 16'h0});
    tag = "R1 R4 R6";  run(2'd3, 1, 1, 0, 0, 3, 8'hA5, 0);
    tag = "R1 R3";     run(2'd0, 0, 1, 0, 12, 2, 8'h96, 0);
    tag = "R1 R4 R7";  run(2'd1, 1, 0, 1, 0, 2, 8'h3C, 0);
    tag = "R8 R3"; stall_mode = 1;
    run(2'd2, 0, 1, 0, 40, 5, 8'h5A, 0);
    stall_mode = 0;
    tag = "R9"; int_en = 2'b11;
    @(negedge clk); int_clr = 2'b01; @(negedge clk); int_clr = 2'b00;
    @(negedge clk); int_clr = 2'b10; @(negedge clk); int_clr = 2'b00;
    tag = "R5"; idle_val = 16'hA5C3; repeat (3) @(negedge clk);
    idle_val = 16'h1E0F; repeat (2) @(negedge clk);
    tag = "R2";        run(2'd0, 1, 1, 0, 0, 2, 8'h71, 1);
    tag = "R3";        run(2'd3, 0, 1, 0, 0, 3, 8'h11, 0);
    tag = "R4";        run(2'd3, 1, 1, 0, 8, 3, 8'hC2, 0);
    tag = "R7 R11";    run(2'd2, 1, 1, 1, 0, 4, 8'h0F, 0);
    tag = "R9"; int_en = 2'b01; int_clr = 2'b11;
    run(2'd1, 0, 1, 0, 6, 1, 8'hE4, 0);
    int_clr = 2'b00; repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule